// File: doc/BRIEF.md
# Wormhole Mesh Router Node

A five-port switching node for a two-dimensional mesh on-chip network. Each port is a flit link toward a neighbouring node or toward a local IP's network interface. Packets are wormhole sequences of flits. The first flit is the header, and it carries a routing path written by the sender. Every node consumes one direction code from that path. The node locks the chosen output to the packet until the tail flit has gone through.

Two virtual channels share each physical link. Channel 0 carries best-effort traffic and channel 1 carries real-time traffic. Each channel has its own input buffer, its own output lock and its own credit loop. On a shared output, a ready real-time flit is sent ahead of best-effort traffic. Headers that compete for the same output channel are served in the order in which they reached the head of their buffers.

Top module: `wh_mesh_router`

## Requirements
- R1: The lowest 3-bit field of a header's path (`body[2:0]`) names the output port (0 to 4, the port index). The header leaves with its 15-bit path shifted right by 3, with zeros shifted in at the top. Other bits and non-header flits leave unchanged.
- R2: Once an output channel is granted to an input, it carries only that packet's flits, in order, until the flit with the tail bit set. After that the lock is released.
- R3: Among headers waiting for the same output channel, the one that has waited longest at the head of its buffer is granted first. If waits are equal, the lower input port index wins.
- R4: On one output, a ready channel 1 flit with credit is sent in preference to channel 0. If channel 1 has no credit, channel 0 flits still flow.
- R5: A flit keeps its channel tag (`in_vc_i` bit = `out_vc_o` bit, 1 = real-time). A blocked channel 0 does not stop channel 1 on the same input or output.
- R6: Each input channel buffers 2 flits. `in_credit_o[i*2+v]` pulses once for each flit that leaves that buffer.
- R7: Each output channel starts with 2 credits after reset. It sends only while its count is above zero. The count drops by one per flit sent and rises by one per `out_credit_i[o*2+v]` pulse.
- R8: In the first cycle after reset is released, no output is valid and no credit pulse is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid_i | input | 5 | Flit present on input port p |
| in_vc_i | input | 5 | Channel tag of the input flit, one bit per port |
| in_flit_i | input | 130 | Input flits, 26 bits per port: {head, tail, body[23:0]} |
| in_credit_o | output | 10 | Credit returned upstream, bit p*2+vc |
| out_valid_o | output | 5 | Flit present on output port p |
| out_vc_o | output | 5 | Channel tag of the output flit |
| out_flit_o | output | 130 | Output flits, 26 bits per port |
| out_credit_i | input | 10 | Credit returned from downstream, bit p*2+vc |

## Verification
The hardest situation to reach is arrival-order arbitration. Several headers must be waiting for one output channel while it is still locked, and each must have arrived in a known cycle. The stimulus creates this by withholding downstream credits for that output, so that a long packet stalls while holding the lock. It then injects competing headers a few cycles apart, or in the same cycle, and releases the credits. The order of the headers at the output is then compared with arrival order and with port index. Real-time preference is forced in a similar way. Both channels are held with long packets on one output, and channel 1 credits are then withheld to show that channel 0 still flows.

// File: rtl/wh_router_pkg.sv
package wh_router_pkg;
    parameter int NPORT     = 5;
    parameter int NVC       = 2;
    parameter int DIRW      = 3;
    parameter int HOPS      = 5;
    parameter int PAYW      = 24;
    parameter int BUF_DEPTH = 2;
    parameter int AGEW      = 8;

    localparam int PATHW = DIRW * HOPS;
    localparam int PIDW  = $clog2(NPORT);
    localparam int VCW   = (NVC > 1) ? $clog2(NVC) : 1;
    localparam int CREDW = $clog2(BUF_DEPTH + 1);
    localparam int BIDW  = (BUF_DEPTH > 1) ? $clog2(BUF_DEPTH) : 1;

    typedef struct packed {
        logic            head;
        logic            tail;
        logic [PAYW-1:0] body;
    } flit_t;

    localparam int FW = $bits(flit_t);

    // consume one direction code from a header's path
    function automatic flit_t hop_shift(flit_t f);
        flit_t r;
        r = f;
        if (f.head) r.body[PATHW-1:0] = f.body[PATHW-1:0] >> DIRW;
        return r;
    endfunction
endpackage

// File: rtl/wh_vc_buffer.sv
module wh_vc_buffer
    import wh_router_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  push_i,
    input  flit_t din_i,
    input  logic  pop_i,
    output flit_t head_o,
    output logic  nempty_o
);
    typedef struct packed {
        flit_t [BUF_DEPTH-1:0] mem;
        logic  [BIDW-1:0]      rd;
        logic  [BIDW-1:0]      wr;
        logic  [CREDW-1:0]     cnt;
    } st_t;

    st_t st_q, st_d;

    function automatic logic [BIDW-1:0] nxt(logic [BIDW-1:0] p);
        return (p == BIDW'(BUF_DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d = st_q;
        if (push_i) begin
            st_d.mem[st_q.wr] = din_i;
            st_d.wr = nxt(st_q.wr);
        end
        if (pop_i) st_d.rd = nxt(st_q.rd);
        st_d.cnt = st_q.cnt + CREDW'(push_i) - CREDW'(pop_i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head_o   = st_q.mem[st_q.rd];
    assign nempty_o = (st_q.cnt != '0);

    // upstream respects the two-slot credit window
    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> (st_q.cnt < CREDW'(BUF_DEPTH)) || pop_i);
    assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> st_q.cnt != '0);
endmodule

// File: rtl/wh_out_port.sv
module wh_out_port
    import wh_router_pkg::*;
(
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic [NVC-1:0][NPORT-1:0]             req_i,
    input  logic [NVC-1:0][NPORT-1:0][AGEW-1:0]   age_i,
    input  flit_t [NVC-1:0]                       cand_flit_i,
    input  logic [NVC-1:0]                        cand_rdy_i,
    input  logic [NVC-1:0]                        credit_i,
    output logic [NVC-1:0]                        lock_v_o,
    output logic [NVC-1:0][PIDW-1:0]              lock_in_o,
    output logic                                  send_o,
    output logic [VCW-1:0]                        sel_vc_o,
    output logic                                  out_valid_o,
    output logic [VCW-1:0]                        out_vc_o,
    output flit_t                                 out_flit_o
);
    typedef struct packed {
        logic [NVC-1:0]             lock_v;
        logic [NVC-1:0][PIDW-1:0]   lock_in;
        logic [NVC-1:0][CREDW-1:0]  cred;
        logic                       oval;
        logic [VCW-1:0]             ovc;
        flit_t                      oflit;
    } st_t;

    st_t            st_q, st_d;
    logic           snd;
    logic [VCW-1:0] sl;

    always_comb begin
        logic            found;
        logic [AGEW-1:0] best;
        logic [PIDW-1:0] pick;
        st_d = st_q;
        st_d.oval = 1'b0;
        snd = 1'b0;
        sl  = '0;
        // highest channel index that is ready wins the link
        for (int v = 0; v < NVC; v++) begin
            if (st_q.lock_v[v] && cand_rdy_i[v] && st_q.cred[v] != '0) begin
                snd = 1'b1;
                sl  = VCW'(v);
            end
        end
        for (int v = 0; v < NVC; v++) begin
            st_d.cred[v] = st_q.cred[v] + CREDW'(credit_i[v])
                         - CREDW'(snd && sl == VCW'(v));
        end
        if (snd) begin
            st_d.oval  = 1'b1;
            st_d.ovc   = sl;
            st_d.oflit = hop_shift(cand_flit_i[sl]);
            if (cand_flit_i[sl].tail) st_d.lock_v[sl] = 1'b0;
        end
        // arrival-order allocation of free output channels
        for (int v = 0; v < NVC; v++) begin
            found = 1'b0;
            best  = '0;
            pick  = '0;
            if (!st_q.lock_v[v]) begin
                for (int i = 0; i < NPORT; i++) begin
                    if (req_i[v][i] && (!found || age_i[v][i] > best)) begin
                        found = 1'b1;
                        best  = age_i[v][i];
                        pick  = PIDW'(i);
                    end
                end
                if (found) begin
                    st_d.lock_v[v]  = 1'b1;
                    st_d.lock_in[v] = pick;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
            for (int v = 0; v < NVC; v++) st_q.cred[v] <= CREDW'(BUF_DEPTH);
        end else begin
            st_q <= st_d;
        end
    end

    assign lock_v_o    = st_q.lock_v;
    assign lock_in_o   = st_q.lock_in;
    assign send_o      = snd;
    assign sel_vc_o    = sl;
    assign out_valid_o = st_q.oval;
    assign out_vc_o    = st_q.ovc;
    assign out_flit_o  = st_q.oflit;

    for (genvar v = 0; v < NVC; v++) begin : g_chk
        assert_lock_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
            st_q.lock_v[v] && !(snd && sl == VCW'(v) && cand_flit_i[v].tail)
            |=> st_q.lock_v[v] && $stable(st_q.lock_in[v]));
        assert_tail_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
            snd && sl == VCW'(v) && cand_flit_i[v].tail |=> !st_q.lock_v[v]);
        assert_credit_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
            st_q.cred[v] <= CREDW'(BUF_DEPTH));
    end

    assert_rt_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
        st_d.oval && st_d.ovc != VCW'(NVC - 1)
        |-> !(st_q.lock_v[NVC-1] && cand_rdy_i[NVC-1] && st_q.cred[NVC-1] != '0));
endmodule

// File: rtl/wh_mesh_router.sv
module wh_mesh_router
    import wh_router_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NPORT-1:0]       in_valid_i,
    input  logic [NPORT*VCW-1:0]   in_vc_i,
    input  logic [NPORT*FW-1:0]    in_flit_i,
    output logic [NPORT*NVC-1:0]   in_credit_o,
    output logic [NPORT-1:0]       out_valid_o,
    output logic [NPORT*VCW-1:0]   out_vc_o,
    output logic [NPORT*FW-1:0]    out_flit_o,
    input  logic [NPORT*NVC-1:0]   out_credit_i
);
    typedef struct packed {
        logic [NVC-1:0][NPORT-1:0][AGEW-1:0] age;
        logic [NPORT-1:0][NVC-1:0]           cred_rtn;
    } st_t;

    st_t st_q, st_d;

    flit_t                     head_f   [NPORT][NVC];
    logic [NPORT-1:0][NVC-1:0] nempty, pop, waiting, bound;
    logic [NPORT-1:0]          own      [NPORT][NVC];
    logic [NVC-1:0][NPORT-1:0] req      [NPORT];
    logic [NVC-1:0]            lock_v   [NPORT];
    logic [NVC-1:0][PIDW-1:0]  lock_in  [NPORT];
    logic [NPORT-1:0]          send;
    logic [VCW-1:0]            sel      [NPORT];
    flit_t [NVC-1:0]           cand_flit[NPORT];
    logic [NVC-1:0]            cand_rdy [NPORT];

    for (genvar i = 0; i < NPORT; i++) begin : g_in
        for (genvar v = 0; v < NVC; v++) begin : g_vc
            wh_vc_buffer u_buf (
                .clk      (clk),
                .rst_n    (rst_n),
                .push_i   (in_valid_i[i] && in_vc_i[i*VCW +: VCW] == VCW'(v)),
                .din_i    (in_flit_i[i*FW +: FW]),
                .pop_i    (pop[i][v]),
                .head_o   (head_f[i][v]),
                .nempty_o (nempty[i][v])
            );
        end
    end

    // request, ownership and candidate wiring (no state)
    always_comb begin
        for (int i = 0; i < NPORT; i++) begin
            for (int v = 0; v < NVC; v++) begin
                for (int o = 0; o < NPORT; o++)
                    own[i][v][o] = lock_v[o][v] && lock_in[o][v] == PIDW'(i);
                bound[i][v]   = |own[i][v];
                waiting[i][v] = nempty[i][v] && head_f[i][v].head && !bound[i][v];
            end
        end
        for (int o = 0; o < NPORT; o++) begin
            for (int v = 0; v < NVC; v++) begin
                for (int i = 0; i < NPORT; i++)
                    req[o][v][i] = waiting[i][v]
                                && head_f[i][v].body[DIRW-1:0] == DIRW'(o);
                cand_flit[o][v] = head_f[lock_in[o][v]][v];
                cand_rdy[o][v]  = nempty[lock_in[o][v]][v];
            end
        end
    end

    for (genvar o = 0; o < NPORT; o++) begin : g_out
        wh_out_port u_out (
            .clk         (clk),
            .rst_n       (rst_n),
            .req_i       (req[o]),
            .age_i       (st_q.age),
            .cand_flit_i (cand_flit[o]),
            .cand_rdy_i  (cand_rdy[o]),
            .credit_i    (out_credit_i[o*NVC +: NVC]),
            .lock_v_o    (lock_v[o]),
            .lock_in_o   (lock_in[o]),
            .send_o      (send[o]),
            .sel_vc_o    (sel[o]),
            .out_valid_o (out_valid_o[o]),
            .out_vc_o    (out_vc_o[o*VCW +: VCW]),
            .out_flit_o  (out_flit_o[o*FW +: FW])
        );
    end

    always_comb begin
        pop = '0;
        for (int o = 0; o < NPORT; o++)
            if (send[o]) pop[lock_in[o][sel[o]]][sel[o]] = 1'b1;
        st_d = st_q;
        st_d.cred_rtn = pop;
        for (int v = 0; v < NVC; v++) begin
            for (int i = 0; i < NPORT; i++) begin
                if (!waiting[i][v])
                    st_d.age[v][i] = '0;
                else if (st_q.age[v][i] != '1)
                    st_d.age[v][i] = st_q.age[v][i] + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign in_credit_o = st_q.cred_rtn;

    for (genvar i = 0; i < NPORT; i++) begin : g_chk
        for (genvar v = 0; v < NVC; v++) begin : g_vc
            assert_dir_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
                waiting[i][v] |-> head_f[i][v].body[DIRW-1:0] < DIRW'(NPORT));
            assert_single_owner_R2: assert property (@(posedge clk) disable iff (!rst_n)
                $countones(own[i][v]) <= 1);
        end
    end

    assert_idle_after_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> out_valid_o == '0 && in_credit_o == '0);
endmodule

// File: tb/tb_wh_mesh_router.sv
`timescale 1ns/1ps
module tb_wh_mesh_router;
    import wh_router_pkg::*;

    localparam int IDW  = PAYW - PATHW;
    localparam int NKEY = NPORT * NVC;
    localparam int MAXP = 1 << IDW;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [NPORT-1:0]     in_valid_i = '0;
    logic [NPORT*VCW-1:0] in_vc_i = '0;
    logic [NPORT*FW-1:0]  in_flit_i = '0;
    logic [NKEY-1:0]      in_credit_o;
    logic [NPORT-1:0]     out_valid_o;
    logic [NPORT*VCW-1:0] out_vc_o;
    logic [NPORT*FW-1:0]  out_flit_o;
    logic [NKEY-1:0]      out_credit_i = '0;

    wh_mesh_router dut (.*);

    always #2 clk = ~clk;

    logic [FW-1:0]  txq [NKEY][$];
    int             hdr_log [NKEY][$];
    int             up_cred [NPORT][NVC];
    int             pend [NPORT][NVC];
    bit             stall [NPORT][NVC];
    int             in_cnt [NPORT][NVC];
    int             out_cnt [NPORT][NVC];
    int             active [NKEY];
    int             p_dest [MAXP], p_vc [MAXP], p_len [MAXP], p_got [MAXP];
    logic [PATHW-1:0] p_path [MAXP];
    bit             p_done [MAXP];
    int             next_id = 0;
    int             n_chk = 0, n_bad = 0;
    bit             running = 1'b0, dn_random = 1'b0, rt_watch = 1'b0;
    int             rt_viol = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    task automatic add_pkt(input int src, input int v, input int dest,
                           input int len, output int id);
        flit_t f;
        logic [PATHW-1:0] path;
        id = next_id++;
        path = '0;
        path[DIRW-1:0] = DIRW'(dest);
        for (int h = 1; h < HOPS; h++) path[h*DIRW +: DIRW] = DIRW'($urandom % NPORT);
        p_dest[id] = dest; p_vc[id] = v; p_len[id] = len; p_path[id] = path;
        p_got[id] = 0; p_done[id] = 1'b0;
        f.head = 1'b1; f.tail = (len == 1); f.body = {IDW'(id), path};
        txq[src*NVC+v].push_back(f);
        for (int s = 1; s < len; s++) begin
            f.head = 1'b0; f.tail = (s == len - 1); f.body = {IDW'(id), PATHW'(s)};
            txq[src*NVC+v].push_back(f);
        end
    endtask

    function automatic bit all_idle();
        for (int k = 0; k < NKEY; k++) if (txq[k].size() != 0) return 1'b0;
        for (int id = 0; id < next_id; id++) if (!p_done[id]) return 1'b0;
        return 1'b1;
    endfunction

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic wait_idle(input string req);
        int t = 0;
        while (!all_idle() && t < 20000) begin cyc(1); t++; end
        chk(all_idle(), req, t, 0);
        cyc(4);
    endtask

    // bench-side model: monitor, credit loops and input drivers
    always @(negedge clk) begin
        if (running) begin
            for (int o = 0; o < NPORT; o++) begin
                if (out_valid_o[o]) begin
                    flit_t f;
                    int v, key, id, seq;
                    f   = out_flit_o[o*FW +: FW];
                    v   = int'(out_vc_o[o*VCW +: VCW]);
                    key = o*NVC + v;
                    id  = int'(f.body[PAYW-1:PATHW]);
                    pend[o][v]++;
                    out_cnt[o][v]++;
                    if (rt_watch && o == 2 && v == 0 && active[2*NVC+1] >= 0) rt_viol++;
                    if (f.head) begin
                        chk(p_dest[id] == o, "R1 header output port", o, p_dest[id]);
                        chk(f.body[PATHW-1:0] == (p_path[id] >> DIRW), "R1 shifted path",
                            int'(f.body[PATHW-1:0]), int'(p_path[id] >> DIRW));
                        chk(p_vc[id] == v, "R5 channel tag kept", v, p_vc[id]);
                        chk(active[key] < 0, "R2 header inside open packet", active[key], -1);
                        p_got[id] = 1;
                        hdr_log[key].push_back(id);
                        if (f.tail) begin
                            chk(p_len[id] == 1, "R2 early tail", 1, p_len[id]);
                            p_done[id] = 1'b1;
                        end else begin
                            active[key] = id;
                        end
                    end else begin
                        seq = int'(f.body[PATHW-1:0]);
                        chk(active[key] == id, "R2 body owner", id, active[key]);
                        chk(seq == p_got[id], "R2 flit order", seq, p_got[id]);
                        p_got[id]++;
                        if (f.tail) begin
                            chk(p_got[id] == p_len[id], "R2 packet length", p_got[id], p_len[id]);
                            p_done[id] = 1'b1;
                            active[key] = -1;
                        end
                    end
                end
            end
            for (int i = 0; i < NPORT; i++)
                for (int v = 0; v < NVC; v++)
                    if (in_credit_o[i*NVC+v]) begin
                        up_cred[i][v]++;
                        in_cnt[i][v]++;
                    end
            out_credit_i = '0;
            for (int o = 0; o < NPORT; o++)
                for (int v = 0; v < NVC; v++)
                    if (pend[o][v] > 0 && !stall[o][v] && (!dn_random || $urandom % 2 == 0)) begin
                        out_credit_i[o*NVC+v] = 1'b1;
                        pend[o][v]--;
                    end
            in_valid_i = '0;
            for (int i = 0; i < NPORT; i++) begin
                int r, pick;
                r = $urandom % NVC;
                pick = -1;
                for (int k = 0; k < NVC; k++) begin
                    int v;
                    v = (r + k) % NVC;
                    if (pick < 0 && txq[i*NVC+v].size() != 0 && up_cred[i][v] > 0) pick = v;
                end
                if (pick >= 0) begin
                    in_valid_i[i] = 1'b1;
                    in_vc_i[i*VCW +: VCW] = VCW'(pick);
                    in_flit_i[i*FW +: FW] = txq[i*NVC+pick].pop_front();
                    up_cred[i][pick]--;
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        summary();
        $finish;
    end

    initial begin
        int a, b, c, d, e, g, h, j, k, base_o, base_i, undone;
        void'($urandom(32'd20240611));
        for (int i = 0; i < NPORT; i++)
            for (int v = 0; v < NVC; v++) begin
                up_cred[i][v] = BUF_DEPTH; pend[i][v] = 0; stall[i][v] = 1'b0;
                in_cnt[i][v] = 0; out_cnt[i][v] = 0;
            end
        for (int q = 0; q < NKEY; q++) active[q] = -1;

        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid_o == '0, "R8 no output after reset", int'(out_valid_o), 0);
        chk(in_credit_o == '0, "R8 no credit after reset", int'(in_credit_o), 0);
        #1 running = 1'b1;

        // R1 / R5: basic forwarding on both channels
        add_pkt(0, 0, 2, 1, a);
        add_pkt(3, 1, 0, 3, b);
        add_pkt(4, 0, 4, 2, c);
        wait_idle("R1 basic packets delivered");

        // R3: arrival order while the output channel is held
        hdr_log[3*NVC].delete();
        stall[3][0] = 1'b1;
        add_pkt(4, 0, 3, 4, a);
        cyc(10);
        add_pkt(1, 0, 3, 2, b);
        cyc(3);
        add_pkt(0, 0, 3, 2, c);
        cyc(10);
        stall[3][0] = 1'b0;
        wait_idle("R3 arrival order drained");
        chk(hdr_log[3*NVC].size() == 3 && hdr_log[3*NVC][1] == b, "R3 older waiter first",
            hdr_log[3*NVC].size() > 1 ? hdr_log[3*NVC][1] : -1, b);
        chk(hdr_log[3*NVC].size() == 3 && hdr_log[3*NVC][2] == c, "R3 newer waiter last",
            hdr_log[3*NVC].size() > 2 ? hdr_log[3*NVC][2] : -1, c);

        // R3: equal wait, lower port index first
        hdr_log[3*NVC].delete();
        stall[3][0] = 1'b1;
        add_pkt(4, 0, 3, 4, d);
        cyc(10);
        add_pkt(2, 0, 3, 1, e);
        add_pkt(1, 0, 3, 1, g);
        cyc(10);
        stall[3][0] = 1'b0;
        wait_idle("R3 tie drained");
        chk(hdr_log[3*NVC].size() == 3 && hdr_log[3*NVC][1] == g, "R3 tie to lower port",
            hdr_log[3*NVC].size() > 1 ? hdr_log[3*NVC][1] : -1, g);

        // R4: real-time preferred on a shared output
        rt_viol = 0;
        rt_watch = 1'b1;
        add_pkt(0, 0, 2, 8, a);
        add_pkt(1, 1, 2, 8, b);
        wait_idle("R4 shared output drained");
        rt_watch = 1'b0;
        chk(rt_viol == 0, "R4 best-effort sent during real-time packet", rt_viol, 0);

        // R4: best-effort flows when real-time lacks credit
        stall[2][1] = 1'b1;
        base_o = out_cnt[2][1];
        add_pkt(1, 1, 2, 6, g);
        cyc(6);
        add_pkt(0, 0, 2, 3, h);
        cyc(20);
        chk(p_done[h], "R4 best-effort passes credit-starved real-time", p_done[h], 1);
        chk(out_cnt[2][1] - base_o == BUF_DEPTH, "R7 real-time limited by credit",
            out_cnt[2][1] - base_o, BUF_DEPTH);
        stall[2][1] = 1'b0;
        wait_idle("R4 starved channel drained");

        // R5: blocked channel 0 does not hold channel 1 on the same link
        stall[1][0] = 1'b1;
        add_pkt(0, 0, 1, 6, j);
        cyc(5);
        add_pkt(0, 1, 1, 3, k);
        cyc(20);
        chk(p_done[k], "R5 real-time passes blocked best-effort", p_done[k], 1);
        chk(!p_done[j], "R5 best-effort held by missing credit", p_done[j], 0);
        stall[1][0] = 1'b0;
        wait_idle("R5 drained");

        // R6 / R7: credit windows on both sides
        stall[4][0] = 1'b1;
        base_o = out_cnt[4][0];
        base_i = in_cnt[2][0];
        add_pkt(2, 0, 4, 5, a);
        cyc(30);
        chk(out_cnt[4][0] - base_o == BUF_DEPTH, "R7 sends stop at zero credit",
            out_cnt[4][0] - base_o, BUF_DEPTH);
        chk(in_cnt[2][0] - base_i == BUF_DEPTH, "R6 one credit per departed flit",
            in_cnt[2][0] - base_i, BUF_DEPTH);
        chk(up_cred[2][0] == 0, "R6 two-flit input buffer full", up_cred[2][0], 0);
        stall[4][0] = 1'b0;
        wait_idle("R7 drained");
        chk(out_cnt[4][0] - base_o == 5, "R7 all flits after credit return",
            out_cnt[4][0] - base_o, 5);

        // random traffic
        dn_random = 1'b1;
        for (int n = 0; n < 300; n++) begin
            add_pkt($urandom % NPORT, $urandom % NVC, $urandom % NPORT,
                    1 + $urandom % 4, a);
            cyc($urandom % 4);
        end
        wait_idle("R2 random traffic drained");
        undone = 0;
        for (int id = 0; id < next_id; id++) if (!p_done[id]) undone++;
        chk(undone == 0, "R2 every packet delivered whole", undone, 0);

        summary();
        $finish;
    end
endmodule